// File: doc/BRIEF.md
# SDRAM Write Burst Column Sequencer

This block sits on the device side of a synchronous DRAM and turns a decoded WRITE command into a stream of array writes. It keeps track of which banks have an open row and how long each row has been open. It holds the write mode: the burst length and a write-style bit. From this it produces one write strobe per cycle, together with the bank, the row, the column and the data word for a memory array port. Write data has zero input latency. The word presented in the same cycle as the WRITE goes to the start column, and each word that follows goes to the next column in the burst order.

Bursts of 2, 4 and 8 words wrap inside their aligned block of columns. A full-page burst walks the whole row, wraps from the last column back to column 0, and keeps writing until a new WRITE or a burst-stop command arrives. A single-write mode bit reduces every WRITE to one word whatever the burst length. A WRITE to a closed bank, or one issued too soon after that bank's ACTIVATE, is rejected and flagged. A mode load that carries a reserved burst-length code is also rejected and flagged.

Top module: `sdram_wr_col_seq`

## Requirements
- R1: After reset, wrEn and errFlag are 0, every bank counts as closed, and the mode is burst-length 1 with burst-style writes.
- R2: Command codes on cmdIn are 000 no-op, 001 ACTIVATE, 010 WRITE, 011 mode load, 100 burst stop, and any other value acts as a no-op. An accepted WRITE puts wrEn=1 on the array port one clock after the command. In that cycle wrCol equals the command's colIn and wrData equals the dataIn presented with the command.
- R3: In burst style with length code 001, 010 or 011, a WRITE gives 2, 4 or 8 strobes on consecutive cycles. The k-th strobe carries the dataIn presented k cycles after the command, and wrEn returns to 0 after the last strobe.
- R4: Within a burst of length N = 2, 4 or 8, columns step up by one and wrap inside the aligned N-column block: the column for step k is (start & ~(N-1)) | ((start + k) & (N-1)).
- R5: Length code 000 writes exactly one word.
- R6: A mode load takes the length code from colIn[2:0] and the write-style bit from colIn[3]. With the style bit at 1, every WRITE writes exactly one word to its own column, whatever the length code.
- R7: Length code 111 selects a full-page burst. The column steps up by one each cycle, goes from LAST_COL back to 0, and writing continues on every cycle with no fixed end.
- R8: A WRITE accepted while a burst is running ends that burst and starts a new one at the new column with the new data, using the current mode.
- R9: A WRITE to a bank with no ACTIVATE since reset, or one issued fewer than T_RCD cycles after that bank's ACTIVATE, raises errFlag for one cycle and produces no strobe. A WRITE exactly T_RCD cycles after the ACTIVATE is accepted.
- R10: A mode load with length code 100, 101 or 110 raises errFlag for one cycle and leaves the previous mode in force.
- R11: Each strobe carries on wrBank the bank of the WRITE, and on wrRow the row that was given with that bank's most recent ACTIVATE.
- R12: A burst-stop command ends a running burst, including a full-page burst. No strobe follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdIn | input | 3 | Decoded command code |
| bankIn | input | BANK_W | Bank address |
| rowIn | input | ROW_W | Row address, used with ACTIVATE |
| colIn | input | COL_W | Column address for WRITE; mode fields for mode load |
| dataIn | input | DATA_W | Write data, zero latency |
| wrEn | output | 1 | Array write strobe |
| wrBank | output | BANK_W | Bank being written |
| wrRow | output | ROW_W | Row being written |
| wrCol | output | COL_W | Column being written |
| wrData | output | DATA_W | Word being written |
| errFlag | output | 1 | One-cycle pulse for a rejected WRITE or mode load |

## Verification
The bench builds the block with LAST_COL set to 15 (a 4-bit column), four banks, T_RCD of 3 and an 8-bit word. With the short page, a full-page burst crosses the 15-to-0 wrap inside about twenty cycles. The same small column range lets the 8-word block wrap, starting at column 13, exercise the upper column bits being held. A T_RCD of 3 puts both the too-early WRITE and the exact-boundary WRITE only a few cycles after an ACTIVATE.

// File: rtl/wsq_pkg.sv
package wsq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_ACT   = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_MODE  = 3'd3,
    CMD_STOP  = 3'd4
  } cmd_e;

  localparam logic [2:0] LEN_ONE   = 3'b000;
  localparam logic [2:0] LEN_TWO   = 3'b001;
  localparam logic [2:0] LEN_FOUR  = 3'b010;
  localparam logic [2:0] LEN_EIGHT = 3'b011;
  localparam logic [2:0] LEN_PAGE  = 3'b111;

  typedef struct packed {
    logic       openRow;
    logic       launch;
    logic       advance;
    logic       pageWrap;
    logic [1:0] blkLog2;
  } seqStrobe_t;

endpackage

// File: rtl/wsq_ctl.sv
module wsq_ctl
  import wsq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 3,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int RCD_W    = $clog2(T_RCD + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cmdIn,
  input  logic [BANK_W-1:0] bankIn,
  input  logic [3:0]        modeBits,
  output seqStrobe_t        strb,
  output logic              errFlag,
  output logic              modeSingle
);

  logic [2:0] lenQ;
  logic       singleQ;
  logic [2:0] burstLeftQ;
  logic       pageQ;
  logic [1:0] blkQ;
  logic       errQ;

  logic       openQ [NUM_BANKS];
  logic [RCD_W-1:0] rcdQ [NUM_BANKS];

  logic isAct, isWrite, isMode, isStop;
  logic lenLegal, writeOk, active;

  assign isAct   = (cmdIn == CMD_ACT);
  assign isWrite = (cmdIn == CMD_WRITE);
  assign isMode  = (cmdIn == CMD_MODE);
  assign isStop  = (cmdIn == CMD_STOP);

  assign lenLegal = (modeBits[2:0] == LEN_ONE)  || (modeBits[2:0] == LEN_TWO) ||
                    (modeBits[2:0] == LEN_FOUR) || (modeBits[2:0] == LEN_EIGHT) ||
                    (modeBits[2:0] == LEN_PAGE);

  assign writeOk = isWrite && openQ[bankIn] && (rcdQ[bankIn] == RCD_W'(T_RCD));
  assign active  = (burstLeftQ != 3'd0) || pageQ;

  // per-bank open flag and row-to-column delay counter
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        openQ[b] <= 1'b0;
        rcdQ[b]  <= '0;
      end else if (isAct && bankIn == BANK_W'(b)) begin
        openQ[b] <= 1'b1;
        rcdQ[b]  <= RCD_W'(1);
      end else if (openQ[b] && rcdQ[b] != RCD_W'(T_RCD)) begin
        rcdQ[b]  <= rcdQ[b] + RCD_W'(1);
      end
    end
  end

  // mode register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenQ    <= LEN_ONE;
      singleQ <= 1'b0;
    end else if (isMode && lenLegal) begin
      lenQ    <= modeBits[2:0];
      singleQ <= modeBits[3];
    end
  end

  // burst progress
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstLeftQ <= 3'd0;
      pageQ      <= 1'b0;
      blkQ       <= 2'd0;
    end else if (writeOk) begin
      pageQ      <= 1'b0;
      burstLeftQ <= 3'd0;
      blkQ       <= 2'd0;
      if (!singleQ) begin
        unique case (lenQ)
          LEN_TWO:   begin burstLeftQ <= 3'd1; blkQ <= 2'd1; end
          LEN_FOUR:  begin burstLeftQ <= 3'd3; blkQ <= 2'd2; end
          LEN_EIGHT: begin burstLeftQ <= 3'd7; blkQ <= 2'd3; end
          LEN_PAGE:  pageQ <= 1'b1;
          default:   ;
        endcase
      end
    end else if (isStop) begin
      burstLeftQ <= 3'd0;
      pageQ      <= 1'b0;
    end else if (active && !pageQ) begin
      burstLeftQ <= burstLeftQ - 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errQ <= 1'b0;
    else       errQ <= (isWrite && !writeOk) || (isMode && !lenLegal);
  end

  always_comb begin
    strb.openRow  = isAct;
    strb.launch   = writeOk;
    strb.advance  = active && !writeOk && !isStop;
    strb.pageWrap = pageQ;
    strb.blkLog2  = blkQ;
  end

  assign errFlag    = errQ;
  assign modeSingle = singleQ;

endmodule

// File: rtl/wsq_dp.sv
module wsq_dp
  import wsq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int LAST_COL  = 511,
  parameter int DATA_W    = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int COL_W    = $clog2(LAST_COL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [BANK_W-1:0] bankIn,
  input  logic [ROW_W-1:0]  rowIn,
  input  logic [COL_W-1:0]  colIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              wrEn,
  output logic [BANK_W-1:0] wrBank,
  output logic [ROW_W-1:0]  wrRow,
  output logic [COL_W-1:0]  wrCol,
  output logic [DATA_W-1:0] wrData
);

  logic [ROW_W-1:0] rowTab [NUM_BANKS];
  logic [COL_W-1:0] blkMask, nextCol;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_row
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                        rowTab[b] <= '0;
      else if (strb.openRow && bankIn == BANK_W'(b))    rowTab[b] <= rowIn;
    end
  end

  assign blkMask = (COL_W'(1) << strb.blkLog2) - COL_W'(1);

  always_comb begin
    if (strb.pageWrap)
      nextCol = (wrCol == COL_W'(LAST_COL)) ? '0 : wrCol + COL_W'(1);
    else
      nextCol = (wrCol & ~blkMask) | ((wrCol + COL_W'(1)) & blkMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEn   <= 1'b0;
      wrBank <= '0;
      wrRow  <= '0;
      wrCol  <= '0;
      wrData <= '0;
    end else begin
      wrEn <= strb.launch || strb.advance;
      if (strb.launch) begin
        wrBank <= bankIn;
        wrRow  <= rowTab[bankIn];
        wrCol  <= colIn;
        wrData <= dataIn;
      end else if (strb.advance) begin
        wrCol  <= nextCol;
        wrData <= dataIn;
      end
    end
  end

endmodule

// File: rtl/sdram_wr_col_seq.sv
module sdram_wr_col_seq
  import wsq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int LAST_COL  = 511,
  parameter int DATA_W    = 8,
  parameter int T_RCD     = 3,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int COL_W    = $clog2(LAST_COL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cmdIn,
  input  logic [BANK_W-1:0] bankIn,
  input  logic [ROW_W-1:0]  rowIn,
  input  logic [COL_W-1:0]  colIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              wrEn,
  output logic [BANK_W-1:0] wrBank,
  output logic [ROW_W-1:0]  wrRow,
  output logic [COL_W-1:0]  wrCol,
  output logic [DATA_W-1:0] wrData,
  output logic              errFlag
);

  seqStrobe_t strb;
  logic       modeSingle;

  wsq_ctl #(.NUM_BANKS(NUM_BANKS), .T_RCD(T_RCD)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdIn     (cmdIn),
    .bankIn    (bankIn),
    .modeBits  (colIn[3:0]),
    .strb      (strb),
    .errFlag   (errFlag),
    .modeSingle(modeSingle)
  );

  wsq_dp #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .LAST_COL(LAST_COL),
           .DATA_W(DATA_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .bankIn(bankIn),
    .rowIn (rowIn),
    .colIn (colIn),
    .dataIn(dataIn),
    .wrEn  (wrEn),
    .wrBank(wrBank),
    .wrRow (wrRow),
    .wrCol (wrCol),
    .wrData(wrData)
  );

endmodule

// File: rtl/sdram_wr_col_seq_chk.sv
module sdram_wr_col_seq_chk
  import wsq_pkg::*;
#(
  parameter int LAST_COL = 511,
  parameter int DATA_W   = 8,
  localparam int COL_W   = $clog2(LAST_COL + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        cmdIn,
  input logic [COL_W-1:0]  colIn,
  input logic [DATA_W-1:0] dataIn,
  input seqStrobe_t        strb,
  input logic              modeSingle,
  input logic              wrEn,
  input logic [COL_W-1:0]  wrCol,
  input logic [DATA_W-1:0] wrData,
  input logic              errFlag
);

  AST_LAUNCH_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strb.launch |=> wrEn && wrCol == $past(colIn) && wrData == $past(dataIn)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strb.launch && !strb.advance |=> !wrEn); // R3

  AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && strb.advance && !strb.pageWrap |=> wrCol[COL_W-1:3] == $past(wrCol[COL_W-1:3])); // R4

  AST_SINGLE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    modeSingle && strb.launch |=> !strb.advance); // R6

  AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && strb.advance && strb.pageWrap && wrCol == COL_W'(LAST_COL) |=> wrCol == '0); // R7

  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !$past(strb.launch)); // R9

  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    cmdIn == CMD_STOP |=> !wrEn); // R12

endmodule

bind sdram_wr_col_seq sdram_wr_col_seq_chk #(.LAST_COL(LAST_COL), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cmdIn     (cmdIn),
  .colIn     (colIn),
  .dataIn    (dataIn),
  .strb      (strb),
  .modeSingle(modeSingle),
  .wrEn      (wrEn),
  .wrCol     (wrCol),
  .wrData    (wrData),
  .errFlag   (errFlag)
);

// File: tb/sdram_wr_col_seq_bench.sv
`timescale 1ns/1ps
module sdram_wr_col_seq_bench;

  localparam int NB = 4, RW = 6, LC = 15, DW = 8, TR = 3;
  localparam int BW = 2, CW = 4;

  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_WR = 3'd2, C_MODE = 3'd3, C_STOP = 3'd4;

  logic clk = 1'b0, rstN = 1'b0;
  logic [2:0] cmdIn = 3'd0;
  logic [BW-1:0] bankIn = '0;
  logic [RW-1:0] rowIn = '0;
  logic [CW-1:0] colIn = '0;
  logic [DW-1:0] dataIn = '0;
  logic wrEn, errFlag;
  logic [BW-1:0] wrBank;
  logic [RW-1:0] wrRow;
  logic [CW-1:0] wrCol;
  logic [DW-1:0] wrData;

  int nChk = 0, nFail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdram_wr_col_seq #(.NUM_BANKS(NB), .ROW_W(RW), .LAST_COL(LC), .DATA_W(DW), .T_RCD(TR))
  u_sdram_wr_col_seq (
    .clk(clk), .rstN(rstN), .cmdIn(cmdIn), .bankIn(bankIn), .rowIn(rowIn),
    .colIn(colIn), .dataIn(dataIn), .wrEn(wrEn), .wrBank(wrBank), .wrRow(wrRow),
    .wrCol(wrCol), .wrData(wrData), .errFlag(errFlag)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive at negedge, clock once, return at the next negedge
  task automatic step(input logic [2:0] c, input int b, input int r, input int col, input int d);
    cmdIn = c; bankIn = BW'(b); rowIn = RW'(r); colIn = CW'(col); dataIn = DW'(d);
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int expCol(input int start, input int k, input int blk);
    if (blk == 0) return (start + k) % (LC + 1);
    return (start & ~(blk - 1)) | ((start + k) & (blk - 1));
  endfunction

  task automatic setMode(input string req, input int code, input int single);
    step(C_MODE, 0, 0, code | (single << 3), 0);
    chk(req, "mode load err", int'(errFlag), 0);
  endtask

  task automatic runBurst(input string req, input int bank, input int start, input int n,
                          input int blk, input int rowExp, input int d0);
    for (int k = 0; k < n; k++) begin
      if (k == 0) step(C_WR, bank, 0, start, d0);
      else        step(C_NOP, 0, 0, 0, d0 + k);
      chk(req, "wrEn", int'(wrEn), 1);
      chk(req, "wrCol", int'(wrCol), expCol(start, k, blk));
      chk(req, "wrData", int'(wrData), (d0 + k) & 8'hff);
      chk("R11", "wrRow", int'(wrRow), rowExp);
      chk("R11", "wrBank", int'(wrBank), bank);
    end
    step(C_NOP, 0, 0, 0, 8'hee);
    chk(req, "wrEn after burst", int'(wrEn), 0);
  endtask

  task automatic tReset();
    chk("R1", "wrEn at reset", int'(wrEn), 0);
    chk("R1", "errFlag at reset", int'(errFlag), 0);
    step(C_WR, 0, 0, 2, 1);
    chk("R1", "closed bank err", int'(errFlag), 1);
    chk("R1", "closed bank wrEn", int'(wrEn), 0);
    step(C_NOP, 0, 0, 0, 0);
  endtask

  task automatic tRcd();
    step(C_ACT, 0, 5, 0, 0);
    step(C_ACT, 1, 9, 0, 0);
    step(C_WR, 1, 0, 3, 7);
    chk("R9", "early write err", int'(errFlag), 1);
    chk("R9", "early write wrEn", int'(wrEn), 0);
    step(C_NOP, 0, 0, 0, 0);
    chk("R9", "err pulse ends", int'(errFlag), 0);
    step(C_WR, 1, 0, 3, 8'h21);
    chk("R9", "boundary write err", int'(errFlag), 0);
    chk("R9", "boundary write wrEn", int'(wrEn), 1);
    chk("R11", "row of bank1", int'(wrRow), 9);
    chk("R2", "col", int'(wrCol), 3);
    chk("R2", "data", int'(wrData), 8'h21);
    step(C_WR, 2, 0, 1, 0);
    chk("R9", "never-opened bank err", int'(errFlag), 1);
    chk("R9", "never-opened bank wrEn", int'(wrEn), 0);
    step(C_NOP, 0, 0, 0, 0);
  endtask

  task automatic tBursts();
    runBurst("R5", 0, 6, 1, 1, 5, 8'h10);
    setMode("R3", 1, 0);
    runBurst("R3", 0, 7, 2, 2, 5, 8'h20);
    setMode("R4", 2, 0);
    runBurst("R4", 0, 6, 4, 4, 5, 8'h30);
    setMode("R4", 3, 0);
    runBurst("R4", 1, 13, 8, 8, 9, 8'h40);
  endtask

  task automatic tSingle();
    setMode("R6", 3, 1);
    runBurst("R6", 0, 13, 1, 8, 5, 8'h50);
    setMode("R6", 7, 1);
    runBurst("R6", 1, 4, 1, 0, 9, 8'h58);
  endtask

  task automatic tPage();
    setMode("R7", 7, 0);
    for (int k = 0; k < 20; k++) begin
      if (k == 0) step(C_WR, 0, 0, 14, 8'h60);
      else        step(C_NOP, 0, 0, 0, 8'h60 + k);
      chk("R7", "wrEn", int'(wrEn), 1);
      chk("R7", "wrCol", int'(wrCol), expCol(14, k, 0));
      chk("R7", "wrData", int'(wrData), 8'h60 + k);
    end
    step(C_STOP, 0, 0, 0, 8'h99);
    chk("R12", "wrEn after stop", int'(wrEn), 0);
    step(C_NOP, 0, 0, 0, 0);
    chk("R12", "wrEn stays low", int'(wrEn), 0);
  endtask

  task automatic tRestart();
    setMode("R8", 2, 0);
    step(C_WR, 0, 0, 1, 8'h70);
    chk("R8", "col", int'(wrCol), 1);
    step(C_NOP, 0, 0, 0, 8'h71);
    chk("R8", "col", int'(wrCol), 2);
    step(C_WR, 0, 0, 9, 8'h80);
    chk("R8", "restart col", int'(wrCol), 9);
    chk("R8", "restart data", int'(wrData), 8'h80);
    for (int k = 1; k < 4; k++) begin
      step(C_NOP, 0, 0, 0, 8'h80 + k);
      chk("R8", "wrEn", int'(wrEn), 1);
      chk("R8", "col", int'(wrCol), expCol(9, k, 4));
      chk("R8", "data", int'(wrData), 8'h80 + k);
    end
    step(C_NOP, 0, 0, 0, 0);
    chk("R8", "wrEn after restarted burst", int'(wrEn), 0);
  endtask

  task automatic tReserved();
    step(C_MODE, 0, 0, 5, 0);
    chk("R10", "reserved code err", int'(errFlag), 1);
    step(C_MODE, 0, 0, 6 | 8, 0);
    chk("R10", "reserved code err", int'(errFlag), 1);
    step(C_NOP, 0, 0, 0, 0);
    chk("R10", "err pulse ends", int'(errFlag), 0);
    runBurst("R10", 0, 12, 4, 4, 5, 8'h90);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tRcd();
    tBursts();
    tSingle();
    tPage();
    tRestart();
    tReserved();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        nChk++;
        nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule